// File: doc/BRIEF.md
# Video Input Timing Meter

This block watches a parallel video stream that arrives with its own pixel clock and works out the timing of that stream. On the pixel clock side it learns which level of each sync line is the active one. It then measures the sync pulse widths, the four porches, and the active width and height. All of these frame fields are captured together at the moment the active vertical sync begins. Both sync polarities are reported live, each as one of three codes.

On a free-running reference clock it counts pixel clock edges over a fixed gate of `REF_KHZ` reference cycles. When the reference clock runs at `REF_KHZ` kHz this gate is one millisecond, so the count reads directly in kHz. The same gate decides the stream status. The stream counts as present only when the link is locked, the pixel clock is running and DE has toggled during the gate. A locked link that carries no active video therefore shows link status 1 and stream status 0.

Top module: `vid_timing_meter`

## Requirements
- R1: `link_ok` follows `link_lock` through a two-flop synchronizer on the reference clock.
- R2: At the end of each gate, `stream_ok` becomes 1 only if three conditions all held: `link_ok` was 1, the pixel clock advanced during the gate, and DE rose at least once during the gate. Otherwise it becomes 0. A locked link with DE held low gives link 1 and stream 0.
- R3: `hs_pol` and `vs_pol` use the codes 0 = active low, 1 = active high and 2 = not available. The active level is the level that was held for the shorter run.
- R4: A sync line that shows no edge for `POL_TO` pixel clocks reports code 2 until two new edges have been seen. Code 2 is also the value after reset.
- R5: `hs_width` and `vs_width` give the length of the active sync pulse in pixel clock ticks.
- R6: `hbp` counts the pixel clocks from the end of the active HSYNC to the first DE=1 pixel. `hfp` counts the pixel clocks from the last DE=1 pixel to the start of the active HSYNC. Both are taken from lines that carry DE.
- R7: `vbp` counts the lines from the end of the active VSYNC to the first line that carries DE. `vfp` counts the lines from the last DE line to the start of the active VSYNC.
- R8: `act_width` is the number of DE=1 pixels on a line. `act_height` is the number of DE lines between two VSYNC pulses.
- R9: All frame fields change together, and only on the pixel clock after the active VSYNC begins. At any other time they hold their values.
- R10: `freq_khz` is the number of pixel clock rising edges seen in the last gate of `REF_KHZ` reference cycles. It is 0 when the pixel clock is stopped.
- R11: After reset, every field, `freq_khz`, `link_ok` and `stream_ok` are 0, and both polarity codes are 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock |
| pclk | input | 1 | Pixel clock of the incoming stream |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| link_lock | input | 1 | Lock flag from the deserializer |
| hs_in | input | 1 | Raw horizontal sync |
| vs_in | input | 1 | Raw vertical sync |
| de_in | input | 1 | Data enable, active high |
| link_ok | output | 1 | Synchronized link status (ref_clk) |
| stream_ok | output | 1 | Stream present status (ref_clk) |
| freq_khz | output | FW | Pixel clock frequency in kHz (ref_clk) |
| hs_pol | output | 2 | HSYNC polarity code (pclk) |
| vs_pol | output | 2 | VSYNC polarity code (pclk) |
| hs_width | output | TW | HSYNC pulse width in pixel clocks |
| vs_width | output | TW | VSYNC pulse width in pixel clocks |
| hbp | output | CW | Horizontal back porch in pixel clocks |
| hfp | output | CW | Horizontal front porch in pixel clocks |
| act_width | output | CW | Active pixels per line |
| vbp | output | LW | Vertical back porch in lines |
| vfp | output | LW | Vertical front porch in lines |
| act_height | output | LW | Active lines per frame |

## Verification
Frame fields describe the previous frame and appear one pixel clock after the active VSYNC starts. Polarity learning can disturb the first frames after a change, so the bench drives five whole frames per configuration and reads the fields at the end of the fifth. Status and frequency are refreshed once per gate and lag by the two- or three-flop synchronizers. Those checks therefore wait several full gates after each change, or are sampled inside a long run of frames. The polarity timeout needs `POL_TO` idle pixel clocks, so that check follows about 90 lines that contain no VSYNC edge.

// File: rtl/vid_timing_meter.sv
module vid_timing_meter #(
  parameter int CW      = 12,
  parameter int LW      = 11,
  parameter int TW      = 24,
  parameter int FW      = 18,
  parameter int REF_KHZ = 100000,
  parameter int POL_TO  = 12000000
) (
  input  logic          ref_clk,
  input  logic          pclk,
  input  logic          rst_n,
  input  logic          link_lock,
  input  logic          hs_in,
  input  logic          vs_in,
  input  logic          de_in,
  output logic          link_ok,
  output logic          stream_ok,
  output logic [FW-1:0] freq_khz,
  output logic [1:0]    hs_pol,
  output logic [1:0]    vs_pol,
  output logic [TW-1:0] hs_width,
  output logic [TW-1:0] vs_width,
  output logic [CW-1:0] hbp,
  output logic [CW-1:0] hfp,
  output logic [CW-1:0] act_width,
  output logic [LW-1:0] vbp,
  output logic [LW-1:0] vfp,
  output logic [LW-1:0] act_height
);
  localparam int GBW = $clog2(REF_KHZ);

  logic [1:0]    sy, pbit, act, act_d;
  logic [TW-1:0] plen  [2];
  logic [1:0]    pcode [2];

  assign sy = {vs_in, hs_in};

  for (genvar gi = 0; gi < 2; gi++) begin : g_sync
    logic          s_d;
    logic [1:0]    edges;
    logic [TW-1:0] run, hi_len, lo_len, idle;
    always_ff @(posedge pclk or negedge rst_n)
      if (!rst_n) begin
        s_d <= 1'b0; edges <= '0; run <= '0; hi_len <= '0; lo_len <= '0; idle <= '0;
      end else begin
        s_d <= sy[gi];
        if (sy[gi] != s_d) begin
          run  <= TW'(1);
          idle <= '0;
          if (s_d) hi_len <= run;
          else     lo_len <= run;
          if (edges != 2'd2) edges <= edges + 2'd1;
        end else begin
          if (run != '1) run <= run + 1'b1;
          if (idle >= TW'(POL_TO)) edges <= '0;
          else                     idle  <= idle + 1'b1;
        end
      end
    assign pbit[gi]  = hi_len < lo_len;
    assign plen[gi]  = pbit[gi] ? hi_len : lo_len;
    assign pcode[gi] = (edges == 2'd2) ? {1'b0, pbit[gi]} : 2'd2;
  end

  assign hs_pol = pcode[0];
  assign vs_pol = pcode[1];
  assign act    = sy ^ ~pbit;

  logic hs_a, vs_a, vs_a_d, line_end, frame_evt;
  assign hs_a      = act[0];
  assign vs_a      = act[1];
  assign vs_a_d    = act_d[1];
  assign line_end  = hs_a & ~act_d[0];
  assign frame_evt = vs_a & ~vs_a_d;

  logic [CW-1:0] bp_cnt, fp_cnt, wcnt, hbp_l, hfp_l, w_l;
  logic          seen_de, line_de;

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      act_d <= '0; bp_cnt <= '0; fp_cnt <= '0; wcnt <= '0;
      hbp_l <= '0; hfp_l <= '0; w_l <= '0; seen_de <= 1'b0; line_de <= 1'b0;
    end else begin
      act_d <= act;
      if (hs_a) begin
        bp_cnt  <= '0;
        seen_de <= 1'b0;
      end else if (de_in && !seen_de) begin
        seen_de <= 1'b1;
        hbp_l   <= bp_cnt;
      end else if (!de_in && !seen_de) begin
        bp_cnt <= bp_cnt + 1'b1;
      end
      if (de_in)      fp_cnt <= '0;
      else if (!hs_a) fp_cnt <= fp_cnt + 1'b1;
      if (line_end)   wcnt <= '0;
      else if (de_in) wcnt <= wcnt + 1'b1;
      if (line_end)   line_de <= 1'b0;
      else if (de_in) line_de <= 1'b1;
      if (line_end && line_de) begin
        hfp_l <= fp_cnt;
        w_l   <= wcnt;
      end
    end

  logic [LW-1:0] vbp_cnt, vfp_cnt, hgt, vbp_l, vfp_nx, hgt_nx;
  logic          seen_vde, blank_end, de_end;

  assign blank_end = line_end & ~vs_a_d & ~line_de;
  assign de_end    = line_end & ~vs_a_d &  line_de;
  assign vfp_nx    = de_end ? '0 : (blank_end ? vfp_cnt + 1'b1 : vfp_cnt);
  assign hgt_nx    = de_end ? hgt + 1'b1 : hgt;

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      vbp_cnt <= '0; vfp_cnt <= '0; hgt <= '0; vbp_l <= '0; seen_vde <= 1'b0;
    end else begin
      if (vs_a) begin
        vbp_cnt  <= '0;
        seen_vde <= 1'b0;
      end else if (de_end && !seen_vde) begin
        seen_vde <= 1'b1;
        vbp_l    <= vbp_cnt;
      end else if (blank_end && !seen_vde) begin
        vbp_cnt <= vbp_cnt + 1'b1;
      end
      vfp_cnt <= vfp_nx;
      hgt     <= frame_evt ? '0 : hgt_nx;
    end

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      hs_width <= '0; vs_width <= '0; hbp <= '0; hfp <= '0; act_width <= '0;
      vbp <= '0; vfp <= '0; act_height <= '0;
    end else if (frame_evt) begin
      hs_width   <= plen[0];
      vs_width   <= plen[1];
      hbp        <= hbp_l;
      hfp        <= hfp_l;
      act_width  <= w_l;
      vbp        <= vbp_l;
      vfp        <= vfp_nx;
      act_height <= hgt_nx;
    end

  logic [FW-1:0] pcnt, pgray;
  logic          de_d, de_tg;

  always_ff @(posedge pclk or negedge rst_n)
    if (!rst_n) begin
      pcnt <= '0; pgray <= '0; de_d <= 1'b0; de_tg <= 1'b0;
    end else begin
      pcnt  <= pcnt + 1'b1;
      pgray <= (pcnt + 1'b1) ^ ((pcnt + 1'b1) >> 1);
      de_d  <= de_in;
      if (de_in && !de_d) de_tg <= ~de_tg;
    end

  logic [FW-1:0]  pg_s1, pg_s2, pbin, last_bin;
  logic [GBW-1:0] gcnt;
  logic           link_s1, de_s1, de_s2, de_s3, de_seen, gate_end, de_chg;

  always_comb
    for (int i = 0; i < FW; i++) pbin[i] = ^(pg_s2 >> i);

  assign gate_end = gcnt == GBW'(REF_KHZ - 1);
  assign de_chg   = de_s3 != de_s2;

  always_ff @(posedge ref_clk or negedge rst_n)
    if (!rst_n) begin
      pg_s1 <= '0; pg_s2 <= '0; last_bin <= '0; gcnt <= '0;
      link_s1 <= 1'b0; link_ok <= 1'b0; de_s1 <= 1'b0; de_s2 <= 1'b0; de_s3 <= 1'b0;
      de_seen <= 1'b0; freq_khz <= '0; stream_ok <= 1'b0;
    end else begin
      pg_s1   <= pgray;
      pg_s2   <= pg_s1;
      link_s1 <= link_lock;
      link_ok <= link_s1;
      de_s1   <= de_tg;
      de_s2   <= de_s1;
      de_s3   <= de_s2;
      gcnt    <= gate_end ? '0 : gcnt + 1'b1;
      de_seen <= gate_end ? 1'b0 : (de_seen | de_chg);
      if (gate_end) begin
        last_bin  <= pbin;
        freq_khz  <= pbin - last_bin;
        stream_ok <= link_ok & (pbin != last_bin) & (de_seen | de_chg);
      end
    end

  assert_pol_code_R3: assert property (@(posedge pclk) disable iff (!rst_n)
    (hs_pol != 2'd3) && (vs_pol != 2'd3));

  assert_fields_hold_R9: assert property (@(posedge pclk) disable iff (!rst_n)
    !frame_evt |=> $stable(act_width) && $stable(act_height) && $stable(vfp) && $stable(hbp));

  assert_freq_hold_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !gate_end |=> $stable(freq_khz) && $stable(stream_ok));

  assert_stream_clock_R2: assert property (@(posedge ref_clk) disable iff (!rst_n)
    stream_ok |-> (freq_khz != '0));

endmodule

// File: tb/sim_vid_timing_meter.sv
`timescale 1ns/1ps
module sim_vid_timing_meter;
  localparam int CW = 12, LW = 11, TW = 24, FW = 18, REF_KHZ = 400, POL_TO = 2000;

  logic ref_clk = 1'b0, pclk = 1'b0, pclk_en = 1'b1, rst_n = 1'b0;
  logic link_lock = 1'b0, hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
  logic link_ok, stream_ok;
  logic [FW-1:0] freq_khz;
  logic [1:0] hs_pol, vs_pol;
  logic [TW-1:0] hs_width, vs_width;
  logic [CW-1:0] hbp, hfp, act_width;
  logic [LW-1:0] vbp, vfp, act_height;

  vid_timing_meter #(.CW(CW), .LW(LW), .TW(TW), .FW(FW), .REF_KHZ(REF_KHZ), .POL_TO(POL_TO)) u0 (
    .ref_clk(ref_clk), .pclk(pclk), .rst_n(rst_n), .link_lock(link_lock),
    .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in), .link_ok(link_ok), .stream_ok(stream_ok),
    .freq_khz(freq_khz), .hs_pol(hs_pol), .vs_pol(vs_pol), .hs_width(hs_width),
    .vs_width(vs_width), .hbp(hbp), .hfp(hfp), .act_width(act_width), .vbp(vbp),
    .vfp(vfp), .act_height(act_height));

  always #2.5 ref_clk = ~ref_clk;
  initial forever begin #4; if (pclk_en) pclk = ~pclk; end

  int n_chk = 0, n_err = 0;
  int hsw, hbpw, hact, hfpw, vsw, vbpl, vact, vfpl, hpol, vpol;

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_range(input string req, input int got, input int lo, input int hi);
    n_chk++;
    if (got < lo || got > hi) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d..%0d", req, got, lo, hi);
    end
  endtask

  function automatic int line_len();
    return hsw + hbpw + hact + hfpw;
  endfunction

  task automatic run_line(input bit vs_act, input bit vis);
    for (int c = 0; c < line_len(); c++) begin
      @(negedge pclk);
      hs_in = hpol[0] ? (c < hsw) : !(c < hsw);
      vs_in = vpol[0] ? vs_act : !vs_act;
      de_in = vis && (c >= hsw + hbpw) && (c < hsw + hbpw + hact);
    end
  endtask

  task automatic run_frame();
    for (int l = 0; l < vsw + vbpl + vact + vfpl; l++)
      run_line(l < vsw, (l >= vsw + vbpl) && (l < vsw + vbpl + vact));
  endtask

  task automatic set_geom(input int g);
    hsw = 3 + g; hbpw = 4 + 2*g; hact = 12 + 4*g; hfpw = 5 - g;
    vsw = 2; vbpl = 2 + g; vact = 6 + g; vfpl = 2 + g;
  endtask

  task automatic check_frame_fields();
    chk("R3 hs_pol", int'(hs_pol), hpol);
    chk("R3 vs_pol", int'(vs_pol), vpol);
    chk("R5 hs_width", int'(hs_width), hsw);
    chk("R5 vs_width", int'(vs_width), vsw * line_len());
    chk("R6 hbp", int'(hbp), hbpw);
    chk("R6 hfp", int'(hfp), hfpw);
    chk("R7 vbp", int'(vbp), vbpl);
    chk("R7 vfp", int'(vfp), vfpl);
    chk("R8 act_width", int'(act_width), hact);
    chk("R8 act_height", int'(act_height), vact);
  endtask

  task automatic finish_up();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    #40;
    chk("R11 hs_pol", int'(hs_pol), 2);
    chk("R11 vs_pol", int'(vs_pol), 2);
    chk("R11 act_width", int'(act_width), 0);
    chk("R11 freq", int'(freq_khz), 0);
    chk("R11 link", int'(link_ok), 0);
    chk("R11 stream", int'(stream_ok), 0);
    @(negedge pclk); rst_n = 1'b1;

    for (int g = 0; g < 2; g++)
      for (int hp = 0; hp < 2; hp++)
        for (int vp = 0; vp < 2; vp++) begin
          set_geom(g); hpol = hp; vpol = vp;
          repeat (5) run_frame();
          #1;
          check_frame_fields();
          chk_range("R10 freq", int'(freq_khz), 249, 251);
          chk("R2 stream unlocked", int'(stream_ok), 0);
        end

    set_geom(0); hpol = 0; vpol = 0;
    repeat (5) run_frame();
    hact = 14; hfpw = 3;
    repeat (4) run_line(1'b0, 1'b1);
    #1;
    chk("R9 width held mid-frame", int'(act_width), 12);
    repeat (3) run_frame();
    #1;
    chk("R9 width after boundary", int'(act_width), 14);
    chk("R8 new width", int'(act_width), hact);

    set_geom(0);
    link_lock = 1'b1;
    fork
      repeat (5) run_frame();
      begin
        #10000;
        chk("R1 link locked", int'(link_ok), 1);
        chk("R2 stream with video", int'(stream_ok), 1);
      end
    join

    repeat (40) run_line(1'b0, 1'b0);
    #1;
    chk("R1 link locked idle", int'(link_ok), 1);
    chk("R2 locked no video", int'(stream_ok), 0);

    link_lock = 1'b0;
    repeat (3) run_frame();
    #1;
    chk("R1 link dropped", int'(link_ok), 0);
    chk("R2 video unlocked", int'(stream_ok), 0);

    chk("R4 vs_pol before idle", int'(vs_pol), 0);
    repeat (90) run_line(1'b0, 1'b0);
    #1;
    chk("R4 vs_pol timeout", int'(vs_pol), 2);
    chk("R4 hs_pol kept", int'(hs_pol), 0);

    link_lock = 1'b1;
    pclk_en = 1'b0;
    #8000;
    chk("R10 freq stopped", int'(freq_khz), 0);
    chk("R2 stream no clock", int'(stream_ok), 0);
    chk("R1 link still locked", int'(link_ok), 1);
    finish_up();
  end
endmodule